// File: doc/BRIEF.md
# Banked Per-State Interrupt Gate

This unit keeps one set of control registers for each of four processor states: a 32-bit interrupt enable mask, a 4-bit arithmetic-condition mask and a 32-bit status word. A vector of pending interrupt conditions enters every cycle. The active-state select chooses which state's registers gate that vector. The gated result leaves on a registered output. Four of the pending bits are arithmetic exception conditions. Each of those also has to pass the matching bit of the active state's arithmetic-condition mask.

The status word of each state holds three things: a privilege flag, a hardware-owned bank bit and an 8-bit call field. A supervisor-call strobe loads a call code into the call field of the state that is active at that moment. A privileged-instruction request made while the active state is unprivileged raises a violation flag in the next cycle. Software reaches every register through write ports. A registered read port shows any one state's registers.

Top module: `pstate_irq_gate`

## Requirements
- R1: A synchronous active-high reset clears every mask and status register in all states to zero. After the reset edge, `irq_masked`, `priv_viol`, `rd_imask`, `rd_pmask` and `rd_stat` read zero.
- R2: `irq_masked` is a register loaded at each clock edge with `pend_i` AND the interrupt mask of the state selected by `act_state`. A mask bit of 1 permits its condition and a mask bit of 0 inhibits it.
- R3: Each state's registers are independent. An interrupt-mask write goes only to the state named by `imask_sel`, and a status write goes only to the state named by `stat_sel`.
- R4: Pending bits 20, 21, 22 and 23 (fixed-point overflow, decimal overflow, exponent underflow, significance) pass only when arithmetic-mask bits 0, 1, 2 and 3 of the active state are also 1. This is in addition to the interrupt mask.
- R5: `pmask_we` loads `pmask_wdata` into the arithmetic mask of the active state, whatever that state's privilege. No other input writes the arithmetic mask.
- R6: A register write takes effect at the clock edge that samples it. The output computed at that same edge still uses the old mask. The output computed at the next edge uses the new mask.
- R7: Status bits 23..16 always read zero. Status writes do not change those bits or bit 14.
- R8: When `svc_strobe` is high, `svc_code` is written into status bits 31..24 of the active state. This overrides a status write to those bits in the same cycle.
- R9: When `bank_load` is high, `bank_val` is written into status bit 14 of the active state. No other input changes that bit.
- R10: `priv_viol` is high in the cycle after `priv_req` is high, if at that edge status bit 15 (1 = unprivileged) of the active state was 1. Otherwise it is low.
- R11: `rd_imask`, `rd_pmask` and `rd_stat` register, at each edge, the registers of the state named by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_state | input | 2 | Active processor state |
| pend_i | input | 32 | Pending interrupt conditions |
| imask_we | input | 1 | Interrupt mask write enable |
| imask_sel | input | 2 | State whose interrupt mask is written |
| imask_wdata | input | 32 | Interrupt mask write data |
| pmask_we | input | 1 | Arithmetic mask write (active state) |
| pmask_wdata | input | 4 | Arithmetic mask write data |
| stat_we | input | 1 | Status word write enable |
| stat_sel | input | 2 | State whose status word is written |
| stat_wdata | input | 32 | Status write data |
| bank_load | input | 1 | Load bank bit of active state |
| bank_val | input | 1 | Bank bit value |
| svc_strobe | input | 1 | Supervisor call strobe |
| svc_code | input | 8 | Supervisor call code |
| priv_req | input | 1 | Privileged instruction request |
| rd_sel | input | 2 | State shown on read port |
| irq_masked | output | 32 | Registered gated pending vector |
| priv_viol | output | 1 | Privilege violation flag |
| rd_imask | output | 32 | Read interrupt mask |
| rd_pmask | output | 4 | Read arithmetic mask |
| rd_stat | output | 32 | Read status word |

## Verification
The assertions assume that every control input is a known level at each rising edge and that reset is held for at least one edge before checking starts. The arithmetic-mask property also assumes that `act_state` holds for one cycle after a mask write. The bench drives every input on the falling edge and holds it through the next rising edge. It keeps `act_state` fixed around each arithmetic-mask write. It compares results on the falling edge against a register model kept in the bench.

// File: rtl/pstate_gate_pkg.sv
package pstate_gate_pkg;
  localparam int STAT_W    = 32;
  localparam int NPRIV_BIT = 15;
  localparam int BANK_BIT  = 14;
  localparam int CALL_LSB  = 24;
  localparam int CALL_W    = 8;
  localparam int PM_BASE   = 20;
  localparam int PM_W      = 4;
  // Bits a software status write may change: not 23..16, not 14.
  localparam logic [STAT_W-1:0] STAT_SW_MASK = 32'hFF00_BFFF;
endpackage

// File: rtl/psg_state_bank.sv
module psg_state_bank
  import pstate_gate_pkg::*;
#(
  parameter int IRQ_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                imask_we,
  input  logic [IRQ_W-1:0]    imask_wdata,
  input  logic                pmask_we,
  input  logic [PM_W-1:0]     pmask_wdata,
  input  logic                stat_we,
  input  logic [STAT_W-1:0]   stat_wdata,
  input  logic                bank_we,
  input  logic                bank_val,
  input  logic                svc_we,
  input  logic [CALL_W-1:0]   svc_code,
  output logic [IRQ_W-1:0]    imask,
  output logic [PM_W-1:0]     pmask,
  output logic [STAT_W-1:0]   status
);
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = status;
    if (stat_we)
      stat_nxt = (stat_wdata & STAT_SW_MASK) | (status & ~STAT_SW_MASK);
    if (bank_we)
      stat_nxt[BANK_BIT] = bank_val;
    if (svc_we)
      stat_nxt[CALL_LSB +: CALL_W] = svc_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imask  <= '0;
      pmask  <= '0;
      status <= '0;
    end else begin
      if (imask_we) imask <= imask_wdata;
      if (pmask_we) pmask <= pmask_wdata;
      status <= stat_nxt;
    end
  end
endmodule

// File: rtl/psg_mask_path.sv
module psg_mask_path
  import pstate_gate_pkg::*;
#(
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] imask,
  input  logic [PM_W-1:0]  pmask,
  output logic [IRQ_W-1:0] irq_q
);
  logic [IRQ_W-1:0] eff;

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    if (b >= PM_BASE && b < PM_BASE + PM_W) begin : g_arith
      assign eff[b] = imask[b] & pmask[b - PM_BASE];
    end else begin : g_plain
      assign eff[b] = imask[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= pend & eff;
  end
endmodule

// File: rtl/psg_priv_check.sv
module psg_priv_check (
  input  logic clk,
  input  logic rst,
  input  logic priv_req,
  input  logic nonpriv,
  output logic viol
);
  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else     viol <= priv_req & nonpriv;
  end
endmodule

// File: rtl/pstate_irq_gate.sv
module pstate_irq_gate
  import pstate_gate_pkg::*;
#(
  parameter int NUM_STATES = 4,
  parameter int IRQ_W      = 32,
  localparam int SEL_W     = $clog2(NUM_STATES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  act_state,
  input  logic [IRQ_W-1:0]  pend_i,
  input  logic              imask_we,
  input  logic [SEL_W-1:0]  imask_sel,
  input  logic [IRQ_W-1:0]  imask_wdata,
  input  logic              pmask_we,
  input  logic [PM_W-1:0]   pmask_wdata,
  input  logic              stat_we,
  input  logic [SEL_W-1:0]  stat_sel,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              bank_load,
  input  logic              bank_val,
  input  logic              svc_strobe,
  input  logic [CALL_W-1:0] svc_code,
  input  logic              priv_req,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [IRQ_W-1:0]  irq_masked,
  output logic              priv_viol,
  output logic [IRQ_W-1:0]  rd_imask,
  output logic [PM_W-1:0]   rd_pmask,
  output logic [STAT_W-1:0] rd_stat
);
  logic [IRQ_W-1:0]  imask_a  [NUM_STATES];
  logic [PM_W-1:0]   pmask_a  [NUM_STATES];
  logic [STAT_W-1:0] status_a [NUM_STATES];

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    logic is_act;
    assign is_act = (act_state == SEL_W'(s));
    psg_state_bank #(.IRQ_W(IRQ_W)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .imask_we    (imask_we && imask_sel == SEL_W'(s)),
      .imask_wdata (imask_wdata),
      .pmask_we    (pmask_we && is_act),
      .pmask_wdata (pmask_wdata),
      .stat_we     (stat_we && stat_sel == SEL_W'(s)),
      .stat_wdata  (stat_wdata),
      .bank_we     (bank_load && is_act),
      .bank_val    (bank_val),
      .svc_we      (svc_strobe && is_act),
      .svc_code    (svc_code),
      .imask       (imask_a[s]),
      .pmask       (pmask_a[s]),
      .status      (status_a[s])
    );
  end

  psg_mask_path #(.IRQ_W(IRQ_W)) u_path (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_i),
    .imask (imask_a[act_state]),
    .pmask (pmask_a[act_state]),
    .irq_q (irq_masked)
  );

  psg_priv_check u_priv (
    .clk      (clk),
    .rst      (rst),
    .priv_req (priv_req),
    .nonpriv  (status_a[act_state][NPRIV_BIT]),
    .viol     (priv_viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_imask <= '0;
      rd_pmask <= '0;
      rd_stat  <= '0;
    end else begin
      rd_imask <= imask_a[rd_sel];
      rd_pmask <= pmask_a[rd_sel];
      rd_stat  <= status_a[rd_sel];
    end
  end
endmodule

// File: rtl/psg_checker.sv
module psg_checker
  import pstate_gate_pkg::*;
#(
  parameter int IRQ_W = 32,
  parameter int SEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  act_state,
  input logic [IRQ_W-1:0]  pend_i,
  input logic              pmask_we,
  input logic [PM_W-1:0]   pmask_wdata,
  input logic              priv_req,
  input logic [IRQ_W-1:0]  irq_masked,
  input logic              priv_viol,
  input logic [IRQ_W-1:0]  rd_imask,
  input logic [PM_W-1:0]   rd_pmask,
  input logic [STAT_W-1:0] rd_stat
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irq_masked == '0 && !priv_viol && rd_imask == '0 &&
             rd_pmask == '0 && rd_stat == '0));

  assert_out_subset_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_masked & ~$past(pend_i)) == '0));

  assert_arith_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (pmask_we && pmask_wdata == '0) ##1 (act_state == $past(act_state) && !pmask_we)
    |=> (irq_masked[PM_BASE +: PM_W] == '0));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd_stat[23:16] == 8'h00);

  assert_viol_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> $past(priv_req));
endmodule

bind pstate_irq_gate psg_checker #(.IRQ_W(IRQ_W), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_state   (act_state),
  .pend_i      (pend_i),
  .pmask_we    (pmask_we),
  .pmask_wdata (pmask_wdata),
  .priv_req    (priv_req),
  .irq_masked  (irq_masked),
  .priv_viol   (priv_viol),
  .rd_imask    (rd_imask),
  .rd_pmask    (rd_pmask),
  .rd_stat     (rd_stat)
);

// File: tb/pstate_irq_gate_tb.sv
module pstate_irq_gate_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  act_state;
  logic [31:0] pend_i;
  logic        imask_we;
  logic [1:0]  imask_sel;
  logic [31:0] imask_wdata;
  logic        pmask_we;
  logic [3:0]  pmask_wdata;
  logic        stat_we;
  logic [1:0]  stat_sel;
  logic [31:0] stat_wdata;
  logic        bank_load;
  logic        bank_val;
  logic        svc_strobe;
  logic [7:0]  svc_code;
  logic        priv_req;
  logic [1:0]  rd_sel;
  logic [31:0] irq_masked;
  logic        priv_viol;
  logic [31:0] rd_imask;
  logic [3:0]  rd_pmask;
  logic [31:0] rd_stat;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_imask [4];
  logic [3:0]  m_pmask [4];
  logic [31:0] m_stat  [4];

  always #5 clk = ~clk;

  pstate_irq_gate u_dut (
    .clk(clk), .rst(rst), .act_state(act_state), .pend_i(pend_i),
    .imask_we(imask_we), .imask_sel(imask_sel), .imask_wdata(imask_wdata),
    .pmask_we(pmask_we), .pmask_wdata(pmask_wdata),
    .stat_we(stat_we), .stat_sel(stat_sel), .stat_wdata(stat_wdata),
    .bank_load(bank_load), .bank_val(bank_val),
    .svc_strobe(svc_strobe), .svc_code(svc_code),
    .priv_req(priv_req), .rd_sel(rd_sel),
    .irq_masked(irq_masked), .priv_viol(priv_viol),
    .rd_imask(rd_imask), .rd_pmask(rd_pmask), .rd_stat(rd_stat)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected gated vector: interrupt mask, plus arithmetic mask on bits 20..23.
  function automatic logic [31:0] exp_irq(input int st, input logic [31:0] pend);
    logic [31:0] gate;
    gate = m_imask[st];
    for (int k = 0; k < 4; k++) gate[20 + k] = gate[20 + k] & m_pmask[st][k];
    return pend & gate;
  endfunction

  task automatic wr_imask(input int st, input logic [31:0] v);
    imask_we = 1'b1; imask_sel = 2'(st); imask_wdata = v;
    cyc();
    imask_we = 1'b0;
    m_imask[st] = v;
  endtask

  task automatic wr_pmask(input int st, input logic [3:0] v);
    act_state = 2'(st); pmask_we = 1'b1; pmask_wdata = v;
    cyc();
    pmask_we = 1'b0;
    m_pmask[st] = v;
  endtask

  task automatic wr_stat(input int st, input logic [31:0] v);
    stat_we = 1'b1; stat_sel = 2'(st); stat_wdata = v;
    cyc();
    stat_we = 1'b0;
    m_stat[st] = (v & 32'hFF00_BFFF) | (m_stat[st] & 32'h00FF_4000);
  endtask

  task automatic rd_chk(input int st, input string tag);
    rd_sel = 2'(st);
    cyc();
    chk({tag, " imask"}, rd_imask, m_imask[st]);
    chk({tag, " pmask"}, {28'd0, rd_pmask}, {28'd0, m_pmask[st]});
    chk({tag, " stat"}, rd_stat, m_stat[st]);
  endtask

  task automatic t_reset();
    rst = 1'b1; act_state = '0; pend_i = '1;
    imask_we = 0; imask_sel = 0; imask_wdata = 0; pmask_we = 0; pmask_wdata = 0;
    stat_we = 0; stat_sel = 0; stat_wdata = 0; bank_load = 0; bank_val = 0;
    svc_strobe = 0; svc_code = 0; priv_req = 1'b1; rd_sel = 0;
    for (int s = 0; s < 4; s++) begin m_imask[s] = 0; m_pmask[s] = 0; m_stat[s] = 0; end
    cyc(); cyc();
    rst = 1'b0;
    cyc();
    chk("R1 irq after reset", irq_masked, 32'h0);
    chk("R1 viol after reset", {31'd0, priv_viol}, 32'h0);
    priv_req = 1'b0;
    for (int s = 0; s < 4; s++) rd_chk(s, "R1 regs zero");
  endtask

  task automatic t_banks();
    wr_imask(0, 32'hFFFF_FFFF);
    wr_imask(1, 32'hA5A5_0F0F);
    wr_imask(2, 32'h00F0_00FF);
    wr_imask(3, 32'h1234_5678);
    wr_pmask(0, 4'hF);
    wr_pmask(1, 4'h3);
    wr_pmask(2, 4'h5);
    wr_pmask(3, 4'hA);
    for (int s = 0; s < 4; s++) rd_chk(s, "R3 R5 R11 bank readback");
    for (int s = 0; s < 4; s++) begin
      act_state = 2'(s);
      pend_i = 32'hFFFF_FFFF;
      cyc();
      chk("R2 R4 all pending", irq_masked, exp_irq(s, pend_i));
      pend_i = 32'h5AC3_3CA5;
      cyc();
      chk("R2 R4 mixed pending", irq_masked, exp_irq(s, pend_i));
    end
    act_state = 2;
    pend_i = 32'h00F0_0000;
    cyc();
    chk("R4 arith bits 20 and 22 only", irq_masked, 32'h0050_0000);
  endtask

  task automatic t_timing();
    logic [32:0] dummy;
    dummy = '0;
    act_state = 0; pend_i = 32'hFFFF_FFFF;
    cyc();
    imask_we = 1; imask_sel = 0; imask_wdata = 32'h0F0F_F0F0;
    cyc();
    chk("R6 same edge uses old mask", irq_masked, exp_irq(0, pend_i));
    imask_we = 0; m_imask[0] = 32'h0F0F_F0F0;
    cyc();
    chk("R6 next edge uses new mask", irq_masked, exp_irq(0, pend_i) | dummy[31:0]);
  endtask

  task automatic t_status();
    wr_stat(1, 32'hFFFF_FFFF);
    rd_chk(1, "R7 reserved bits");
    chk("R7 exact value", rd_stat, 32'hFF00_BFFF);
    rd_chk(0, "R3 state0 untouched");
  endtask

  task automatic t_svc();
    act_state = 3;
    svc_strobe = 1; svc_code = 8'h5A;
    stat_we = 1; stat_sel = 3; stat_wdata = 32'h1200_8001;
    cyc();
    svc_strobe = 0; stat_we = 0;
    m_stat[3] = 32'h5A00_8001;
    rd_chk(3, "R8 call field overrides");
    rd_chk(2, "R8 other state untouched");
  endtask

  task automatic t_bank();
    act_state = 2; bank_load = 1; bank_val = 1;
    cyc();
    bank_load = 0;
    m_stat[2][14] = 1'b1;
    rd_chk(2, "R9 bank bit set");
    wr_stat(2, 32'h0000_0000);
    rd_chk(2, "R9 bank bit kept by status write");
  endtask

  task automatic t_priv();
    act_state = 0; priv_req = 1;
    cyc();
    chk("R10 privileged state no viol", {31'd0, priv_viol}, 32'h0);
    act_state = 1;
    cyc();
    chk("R10 unprivileged viol", {31'd0, priv_viol}, 32'h1);
    priv_req = 0;
    cyc();
    chk("R10 one cycle only", {31'd0, priv_viol}, 32'h0);
    priv_req = 1; stat_we = 1; stat_sel = 1; stat_wdata = 32'h0;
    cyc();
    chk("R10 old bit at write edge", {31'd0, priv_viol}, 32'h1);
    stat_we = 0;
    m_stat[1] = 32'h0;
    cyc();
    chk("R10 cleared bit no viol", {31'd0, priv_viol}, 32'h0);
    priv_req = 0;
  endtask

  initial begin
    t_reset();
    t_banks();
    t_timing();
    t_status();
    t_svc();
    t_bank();
    t_priv();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule